// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash memory and decides whether a program or erase operation that is already under way has finished. After a single-cycle `start`, it reads the device status byte over a simple request/acknowledge read port. It always reads in pairs: the first read stores the monitored toggle bit, and the second read is compared against it. A toggle bit that stays the same means the device has finished and now returns array data again. A bit that flips means the device is still busy, unless the device has also raised its time-limit flag.

When the flag is raised, the block makes one extra confirming pair of reads, because the toggling may have stopped at the same moment the flag went high. If the bit is steady on that pair, the operation succeeded. If it is still flipping, the operation failed: the block writes the reset command byte once through a request/acknowledge write port, which returns the device to array reads, and then reports failure. A configurable loop limit gives up in the same way if the device keeps toggling but never raises its flag.

The caller watches `busy` and the two one-cycle result pulses. The command sequence that started the operation, the bus timing and the choice of sectors all belong to other logic.

Top module: `toggle_poll_fsm`

## Requirements
- R1: After reset, `busy`, `rd_req`, `wr_req`, `done_ok` and `done_fail` are low. A `start` seen while idle raises `busy` and `rd_req` in the next cycle.
- R2: Each check is a pair of back-to-back reads. If the toggle bit is equal in both reads, the block pulses `done_ok`, makes no write, and drops `busy` in the same cycle as the pulse.
- R3: Only status bit TOGGLE_BIT (default 6) is compared. Other bits that differ between the two reads do not count as toggling.
- R4: If the toggle bit differs and the time-limit bit (bit TIMEOUT_BIT, default 5) of the second read is low, a new pair follows. If that bit is high, a confirming pair follows. The time-limit bit has no effect when the toggle bit did not differ.
- R5: If the confirming pair shows a steady toggle bit, the block pulses `done_ok` with no write.
- R6: If the confirming pair still toggles, the block raises `wr_req` with `wr_data` = RESET_CMD (default 0xF0), holds it until `wr_ack`, issues exactly one write, and then pulses `done_fail`.
- R7: `done_ok` and `done_fail` last one cycle each, are never high together, and appear only in the cycle after the last acknowledge of the operation.
- R8: When the MAX_LOOPS-th toggling pair with the time-limit bit low is seen, the block takes the failure path of R6. The count restarts for each operation, and MAX_LOOPS = 0 turns the limit off.
- R9: `start` is ignored while `busy` is high.
- R10: `rd_req` and `wr_req` stay high until they are acknowledged, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (used only while idle) |
| busy | output | 1 | Polling in progress |
| done_ok | output | 1 | One-cycle pulse: the operation completed |
| done_fail | output | 1 | One-cycle pulse: the operation failed and the reset command was written |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | 8 | Status byte returned by the device |
| wr_req | output | 1 | Command write request, held until acknowledged |
| wr_data | output | 8 | Command byte to write (the reset command) |
| wr_ack | input | 1 | Write acknowledge |

## Verification
The ports expose a wrong internal state within a single operation. A stale stored toggle bit, or a first-read capture made at the wrong time, turns a steady pair into a toggling one or the reverse. This shows up as extra reads or as the wrong result pulse once the pair's second acknowledge has landed. A confirm flag or loop count that is not cleared between operations makes a later, healthy operation fail early, with a `wr_req` and fewer reads than its script contains. Each scenario is therefore checked on its read count and write count as well as on the result pulse, so that a decision taken one pair too early or too late is caught.

// File: rtl/toggle_poll_pkg.sv
// Package: shared state encoding for the toggle-bit completion poller.
// Assumes: nothing beyond IEEE 1800-2017.
package toggle_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for start
        ST_FIRST = 2'd1,   // first read of a pair outstanding
        ST_SECND = 2'd2,   // second read of a pair outstanding
        ST_RESET = 2'd3    // reset command write outstanding
    } poll_state_e;

endpackage

// File: rtl/toggle_poll_cmp.sv
// Module: toggle_poll_cmp
// Stores the monitored bit from the first read of a pair. It flags whether
// the second read differs, and passes on the second read's time-limit bit.
// Assumes: `cap_first` is asserted only on the first read's acknowledge.
module toggle_poll_cmp #(
    parameter int DATA_W      = 8,
    parameter int TOGGLE_BIT  = 6,
    parameter int TIMEOUT_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_first,
    input  logic [DATA_W-1:0] sample,
    output logic              toggled,
    output logic              timed_out
);

    logic first_q;

    // Hold the toggle bit seen on the first read of the current pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= 1'b0;
        else if (cap_first)
            first_q <= sample[TOGGLE_BIT];
    end

    // Compare the current sample with the stored bit.
    always_comb begin
        toggled   = sample[TOGGLE_BIT] ^ first_q;
        timed_out = sample[TIMEOUT_BIT];
    end

endmodule

// File: rtl/toggle_poll_guard.sv
// Module: toggle_poll_guard
// Counts toggling pairs that came without a time-limit flag and signals
// when the current step is the MAX_LOOPS-th. MAX_LOOPS = 0 removes the counter.
// Assumes: `clear` and `step` are never asserted together.
module toggle_poll_guard #(
    parameter int MAX_LOOPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic limit_hit
);

    generate
        if (MAX_LOOPS == 0) begin : g_off
            assign limit_hit = 1'b0;
        end else begin : g_on
            localparam int LOOP_W = $clog2(MAX_LOOPS + 1);
            localparam logic [LOOP_W-1:0] LAST = LOOP_W'(MAX_LOOPS - 1);
            logic [LOOP_W-1:0] cnt_q;

            // Count steps since the last clear.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    cnt_q <= '0;
                else if (step)
                    cnt_q <= cnt_q + 1'b1;
            end

            // This step reaches the limit.
            assign limit_hit = step && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/toggle_poll_fsm.sv
// Module: toggle_poll_fsm (top)
// Polls a flash status byte in pairs of reads until the toggle bit stops
// changing. After a time-limit flag it confirms with one more pair, and on
// failure it writes the reset command once and reports the failure.
// Assumes: the device sends one acknowledge per request cycle run;
// `rd_data` is valid only while `rd_ack` is high.
module toggle_poll_fsm
    import toggle_poll_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          TOGGLE_BIT  = 6,
    parameter int          TIMEOUT_BIT = 5,
    parameter logic [7:0]  RESET_CMD   = 8'hF0,
    parameter int          MAX_LOOPS   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done_ok,
    output logic              done_fail,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack
);

    poll_state_e state_q, state_d;
    logic        confirm_q, confirm_d;
    logic        ok_d, fail_d;
    logic        toggled, timed_out, limit_hit;
    logic        go, second_ack, loop_step;

    assign go         = (state_q == ST_IDLE) && start;
    assign second_ack = (state_q == ST_SECND) && rd_ack;
    assign loop_step  = second_ack && toggled && !confirm_q && !timed_out;

    toggle_poll_cmp #(
        .DATA_W      (DATA_W),
        .TOGGLE_BIT  (TOGGLE_BIT),
        .TIMEOUT_BIT (TIMEOUT_BIT)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_first ((state_q == ST_FIRST) && rd_ack),
        .sample    (rd_data),
        .toggled   (toggled),
        .timed_out (timed_out)
    );

    toggle_poll_guard #(
        .MAX_LOOPS (MAX_LOOPS)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (go),
        .step      (loop_step),
        .limit_hit (limit_hit)
    );

    // Next-state and result decision.
    always_comb begin
        state_d   = state_q;
        confirm_d = confirm_q;
        ok_d      = 1'b0;
        fail_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_FIRST;
                    confirm_d = 1'b0;
                end
            end
            ST_FIRST: begin
                if (rd_ack) state_d = ST_SECND;
            end
            ST_SECND: begin
                if (rd_ack) begin
                    if (!toggled) begin
                        state_d = ST_IDLE;
                        ok_d    = 1'b1;
                    end else if (confirm_q || limit_hit) begin
                        state_d = ST_RESET;
                    end else if (timed_out) begin
                        state_d   = ST_FIRST;
                        confirm_d = 1'b1;
                    end else begin
                        state_d = ST_FIRST;
                    end
                end
            end
            ST_RESET: begin
                if (wr_ack) begin
                    state_d = ST_IDLE;
                    fail_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, confirm flag and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            confirm_q <= 1'b0;
            done_ok   <= 1'b0;
            done_fail <= 1'b0;
        end else begin
            state_q   <= state_d;
            confirm_q <= confirm_d;
            done_ok   <= ok_d;
            done_fail <= fail_d;
        end
    end

    // Port outputs decoded from the state.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        rd_req  = (state_q == ST_FIRST) || (state_q == ST_SECND);
        wr_req  = (state_q == ST_RESET);
        wr_data = DATA_W'(RESET_CMD);
    end

endmodule

// File: rtl/toggle_poll_chk.sv
// Module: toggle_poll_chk
// Port-level protocol checks for toggle_poll_fsm, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module toggle_poll_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done_ok,
    input logic              done_fail,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_req,
    input logic              wr_ack
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_req));

    p_start_reads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && rd_req));

    p_ok_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> (!busy && $past(rd_ack)));

    p_fail_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_fail |-> (!busy && $past(wr_req && wr_ack)));

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data)));

    p_ok_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |=> !done_ok);

    p_fail_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_fail |=> !done_fail);

    p_one_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_fail));

    p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_ack && !wr_ack) |=> busy);

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

endmodule

bind toggle_poll_fsm toggle_poll_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done_ok   (done_ok),
    .done_fail (done_fail),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .wr_data   (wr_data),
    .wr_req    (wr_req),
    .wr_ack    (wr_ack)
);

// File: tb/toggle_poll_fsm_bench.sv
// Scoreboard bench: a driver task loads a scripted status-byte sequence and
// pushes the expected result; a monitor pops and compares at each result pulse.
module toggle_poll_fsm_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done_ok, done_fail, rd_req, wr_req;
    logic       rd_ack = 1'b0;
    logic       wr_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int reads_cnt = 0;
    int wr_cnt = 0;
    logic [7:0] last_wr = 8'h00;
    logic [7:0] script_q [$];

    typedef struct {
        string req;
        bit    ok;
        int    reads;
    } exp_t;
    exp_t exp_q [$];

    always #2.5 clk = ~clk;   // 200 MHz

    toggle_poll_fsm #(.MAX_LOOPS(4)) u_toggle_poll_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .done_ok(done_ok), .done_fail(done_fail),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack)
    );

    // Device model: acknowledge each request one cycle later with scripted data.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack <= 1'b0;
            wr_ack <= 1'b0;
        end else begin
            if (rd_req && !rd_ack) begin
                rd_ack    <= 1'b1;
                rd_data   <= (script_q.size() > 0) ? script_q.pop_front() : 8'h00;
                reads_cnt <= reads_cnt + 1;
            end else begin
                rd_ack <= 1'b0;
            end
            if (wr_req && !wr_ack) begin
                wr_ack  <= 1'b1;
                wr_cnt  <= wr_cnt + 1;
                last_wr <= wr_data;
            end else begin
                wr_ack <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop the expected result at each result pulse and compare.
    always @(negedge clk) begin
        if (rst_n && (done_ok || done_fail)) begin
            if (exp_q.size() == 0) begin
                check("R9", "unexpected result pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R7", "single result", int'(done_ok && done_fail), 0);
                check(e.req, "done_ok", int'(done_ok), int'(e.ok));
                check(e.req, "read count", reads_cnt, e.reads);
                check(e.req, "write count", wr_cnt, e.ok ? 0 : 1);
                if (!e.ok) check("R6", "reset command byte", int'(last_wr), 8'hF0);
                check("R2", "busy low with result", int'(busy), 0);
            end
        end
    end

    // Driver: load the script (byte 0 is read first), push the expectation, start.
    task automatic run_case(input string req, input bit ok, input int n,
                            input logic [63:0] bytes, input bit poke);
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        reads_cnt = 0;
        wr_cnt    = 0;
        for (int i = 0; i < n; i++) script_q.push_back(bytes[8*i +: 8]);
        exp_q.push_back('{req: req, ok: ok, reads: n});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1", "busy and rd_req after start", int'(busy && rd_req), 1);
        if (poke) begin
            @(negedge clk);
            start = 1'b1;   // R9: must be ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(req, "no extra activity after result", int'(busy || rd_req || wr_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "rd_req after reset", int'(rd_req), 0);
        check("R1", "wr_req after reset", int'(wr_req), 0);
        check("R1", "results after reset", int'(done_ok || done_fail), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: steady toggle bit at once.
        run_case("R2", 1'b1, 2, 64'h0000, 1'b0);
        // R3: bit 2 and others change, bit 6 steady.
        run_case("R3", 1'b1, 2, 64'h7B44, 1'b0);
        // R4: time-limit bit high but no toggle, so it is ignored.
        run_case("R4", 1'b1, 2, 64'h2020, 1'b0);
        // R4: three toggling pairs with the flag low, then steady.
        run_case("R4", 1'b1, 8, 64'h4040_4000_0040_4000, 1'b0);
        // R5: flag high, confirming pair steady.
        run_case("R5", 1'b1, 4, 64'h6060_6000, 1'b0);
        // R6: flag high, confirming pair still toggling.
        run_case("R6", 1'b0, 4, 64'h2060_6000, 1'b0);
        // R8: four toggling pairs with no flag reach the loop limit.
        run_case("R8", 1'b0, 8, 64'h4000_4000_4000_4000, 1'b0);
        // R8: count restarts, so three loops pass again.
        run_case("R8", 1'b1, 8, 64'h4040_4000_0040_4000, 1'b0);
        // R9: second start during the run is ignored.
        run_case("R9", 1'b1, 2, 64'h4040, 1'b1);
        // R10 relies on the device model acknowledging single requests.
        check("R10", "script consumed", script_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule